// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer descriptors kept in system memory. Each table entry describes one receive buffer: a 32-bit buffer base and a 32-bit remaining-length count in 16-bit words. When a fetch is requested, the block issues one burst read of four beats. It assembles the four 16-bit fields from those beats and publishes the buffer base and word count to the receive datapath. It then moves its read pointer to the next entry, wrapping at the end of the ring.

A fetch starts in one of two ways. The host can set a read-resource command, which reads back as pending until the fetch it caused completes. The receive datapath can report the end of a frame that used up its buffer. In that case the block either fetches the next entry or, if the read pointer has caught the host's write pointer, raises a flag that blocks reception until a later fetch completes. A one-cycle exhaustion pulse marks the moment the ring runs dry.

Top module: `rx_ring_fetch`

## Requirements
- R1: An entry is four 16-bit fields read in this order: buffer base bits 15:0, buffer base bits 31:16, word count bits 15:0, word count bits 31:16. They are delivered as burst beats 0 to 3. On completion `buf_addr` and `buf_words` show the assembled 32-bit values.
- R2: With `cfg_wide`=1 each field occupies a 4-byte slot and the entry stride is 16 bytes. With `cfg_wide`=0 each field occupies a 2-byte slot, the field is `mem_rsp_data[15:0]`, and the stride is 8 bytes.
- R3: The burst start address is `{ring_upper, read_ptr}`. It is held stable while `mem_rd_req` waits for `mem_rd_ready`.
- R4: After each fetch, `read_ptr` advances by the stride. If the advanced value equals `ring_end`, `read_ptr` becomes `ring_start` instead.
- R5: If the new `read_ptr` equals `host_wp`, `exhausted` is high for exactly one cycle, in the cycle where the new pointer first appears. Otherwise it stays low.
- R6: Every completed fetch clears `rx_blocked`.
- R7: A `frame_end` pulse with `frame_last`=1 sets `rx_blocked` without any memory request when `read_ptr` equals `host_wp`. Otherwise it starts a fetch. A `frame_end` pulse with `frame_last`=0 changes nothing.
- R8: A `cmd_fetch` pulse sets `cmd_pending`, which starts a fetch. `cmd_pending` clears when that fetch completes.
- R9: With `cfg_wide`=1, the field is `mem_rsp_data[31:16]` when `cfg_big_endian`=1 and `mem_rsp_data[15:0]` when it is 0.
- R10: `busy` is high from the burst request until completion. A fetch request arriving while busy is held and served after the current fetch. A pending command is served before a pending frame end.
- R11: After reset, `read_ptr`, `buf_addr` and `buf_words` are zero, and `busy`, `cmd_pending`, `rx_blocked`, `exhausted` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| cfg_big_endian | input | 1 | Upper-half field select in wide mode |
| ring_upper | input | 16 | Upper 16 address bits of the ring |
| ring_start | input | 16 | Ring start pointer |
| ring_end | input | 16 | Ring end pointer (exclusive) |
| host_wp | input | 16 | Host write pointer |
| rp_wr_en | input | 1 | Load read pointer (taken when not busy) |
| rp_wr_data | input | 16 | Value for read pointer |
| cmd_fetch | input | 1 | Read-resource command pulse |
| frame_end | input | 1 | Frame finished pulse |
| frame_last | input | 1 | Frame exhausted its buffer |
| mem_rd_req | output | 1 | Burst read request |
| mem_rd_addr | output | 32 | Burst start address |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 32 | Response beat data |
| buf_addr | output | 32 | Current buffer base |
| buf_words | output | 32 | Current remaining word count |
| read_ptr | output | 16 | Ring read pointer |
| cmd_pending | output | 1 | Read-resource command in progress |
| busy | output | 1 | Fetch in flight |
| exhausted | output | 1 | One-cycle ring-exhausted pulse |
| rx_blocked | output | 1 | Last resource full, reception blocked |

## Verification
Fetches run in wide little-endian, wide big-endian and narrow mode. The memory model returns a distinct value in each half of every slot, so a wrong lane or stride gives a different assembled base and count. Pointer sequences are arranged so that one step lands on the write pointer, one step lands on the end pointer, and one does neither. This separates the exhaustion pulse from the wrap. Frame-end pulses are sent with the pointers equal, with them unequal, and without the last flag, which separates blocking, fetching and ignoring. A stalled request with a frame end arriving during it shows that the address is held and that the queued request is served afterwards.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    localparam int PTR_W      = 16;
    localparam int FIELD_W    = 16;
    localparam int BUS_W      = 32;
    localparam int BEATS      = 4;
    localparam int SLOT_WIDE  = 4;
    localparam int SLOT_NARROW = 2;
    localparam int BEAT_IDX_W = $clog2(BEATS);

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_DATA,
        FS_DONE
    } fetch_state_e;

    typedef enum logic {
        SRC_CMD,
        SRC_FRAME
    } fetch_src_e;

    typedef struct packed {
        logic [2*FIELD_W-1:0] words;
        logic [2*FIELD_W-1:0] base;
    } rsrc_entry_t;

    function automatic logic [PTR_W-1:0] entry_stride(input logic wide);
        return wide ? PTR_W'(SLOT_WIDE * BEATS) : PTR_W'(SLOT_NARROW * BEATS);
    endfunction
endpackage

// File: rtl/rr_lane_pick.sv
module rr_lane_pick
    import rx_ring_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int FW = FIELD_W
) (
    input  logic          wide,
    input  logic          big_endian,
    input  logic [BW-1:0] beat,
    output logic [FW-1:0] field
);
    always_comb begin
        if (wide && big_endian) field = beat[BW-1 -: FW];
        else                    field = beat[FW-1:0];
    end
endmodule

// File: rtl/rr_ptr_step.sv
module rr_ptr_step
    import rx_ring_pkg::*;
#(
    parameter int PW = PTR_W
) (
    input  logic [PW-1:0] rp,
    input  logic          wide,
    input  logic [PW-1:0] ring_start,
    input  logic [PW-1:0] ring_end,
    input  logic [PW-1:0] host_wp,
    output logic [PW-1:0] rp_next,
    output logic          next_hits_wp
);
    logic [PW-1:0] advanced;

    always_comb begin
        advanced     = rp + PW'(entry_stride(wide));
        rp_next      = (advanced == ring_end) ? ring_start : advanced;
        next_hits_wp = (rp_next == host_wp);
    end
endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
    import rx_ring_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_fetch,
    input  logic                  frame_end,
    input  logic                  frame_last,
    input  logic                  rp_eq_wp,
    input  logic                  mem_rd_ready,
    input  logic                  mem_rsp_valid,
    output logic                  mem_rd_req,
    output logic                  busy,
    output logic                  beat_take,
    output logic [BEAT_IDX_W-1:0] beat_idx,
    output logic                  commit,
    output logic                  cmd_pending,
    output logic                  rx_blocked
);
    localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BEATS - 1);

    fetch_state_e          state;
    fetch_src_e            src;
    logic                  last_pend;
    logic [BEAT_IDX_W-1:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= FS_IDLE;
            src         <= SRC_CMD;
            last_pend   <= 1'b0;
            beat_cnt    <= '0;
            cmd_pending <= 1'b0;
            rx_blocked  <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (cmd_pending) begin
                        state <= FS_REQ;
                        src   <= SRC_CMD;
                    end else if (last_pend) begin
                        last_pend <= 1'b0;
                        if (rp_eq_wp) begin
                            rx_blocked <= 1'b1;
                        end else begin
                            state <= FS_REQ;
                            src   <= SRC_FRAME;
                        end
                    end
                end
                FS_REQ: begin
                    if (mem_rd_ready) begin
                        state    <= FS_DATA;
                        beat_cnt <= '0;
                    end
                end
                FS_DATA: begin
                    if (mem_rsp_valid) begin
                        beat_cnt <= beat_cnt + 1'b1;
                        if (beat_cnt == LAST_BEAT) state <= FS_DONE;
                    end
                end
                FS_DONE: begin
                    rx_blocked <= 1'b0;
                    if (src == SRC_CMD) cmd_pending <= 1'b0;
                    state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
            if (cmd_fetch) cmd_pending <= 1'b1;
            if (frame_end && frame_last) last_pend <= 1'b1;
        end
    end

    always_comb begin
        mem_rd_req = (state == FS_REQ);
        busy       = (state != FS_IDLE);
        beat_take  = (state == FS_DATA) && mem_rsp_valid;
        beat_idx   = beat_cnt;
        commit     = (state == FS_DONE);
    end

    AST_CMD_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_pending) |-> $past(commit)); // R8
    AST_BLOCK_ONLY_AT_WP: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_blocked) |-> $past(rp_eq_wp)); // R7
    AST_BLOCK_CLEARED_BY_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(commit) |-> !rx_blocked); // R6
endmodule

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch
    import rx_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wide,
    input  logic                 cfg_big_endian,
    input  logic [15:0]          ring_upper,
    input  logic [PTR_W-1:0]     ring_start,
    input  logic [PTR_W-1:0]     ring_end,
    input  logic [PTR_W-1:0]     host_wp,
    input  logic                 rp_wr_en,
    input  logic [PTR_W-1:0]     rp_wr_data,
    input  logic                 cmd_fetch,
    input  logic                 frame_end,
    input  logic                 frame_last,
    output logic                 mem_rd_req,
    output logic [31:0]          mem_rd_addr,
    input  logic                 mem_rd_ready,
    input  logic                 mem_rsp_valid,
    input  logic [BUS_W-1:0]     mem_rsp_data,
    output logic [2*FIELD_W-1:0] buf_addr,
    output logic [2*FIELD_W-1:0] buf_words,
    output logic [PTR_W-1:0]     read_ptr,
    output logic                 cmd_pending,
    output logic                 busy,
    output logic                 exhausted,
    output logic                 rx_blocked
);
    logic                  beat_take;
    logic [BEAT_IDX_W-1:0] beat_idx;
    logic                  commit;
    logic [FIELD_W-1:0]    field;
    logic [PTR_W-1:0]      rp_next;
    logic                  next_hits_wp;
    logic [FIELD_W-1:0]    stage [BEATS];
    rsrc_entry_t           entry_q;

    rr_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_fetch    (cmd_fetch),
        .frame_end    (frame_end),
        .frame_last   (frame_last),
        .rp_eq_wp     (read_ptr == host_wp),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rd_req   (mem_rd_req),
        .busy         (busy),
        .beat_take    (beat_take),
        .beat_idx     (beat_idx),
        .commit       (commit),
        .cmd_pending  (cmd_pending),
        .rx_blocked   (rx_blocked)
    );

    rr_lane_pick #(.BW(BUS_W), .FW(FIELD_W)) u_lane (
        .wide      (cfg_wide),
        .big_endian(cfg_big_endian),
        .beat      (mem_rsp_data),
        .field     (field)
    );

    rr_ptr_step #(.PW(PTR_W)) u_step (
        .rp          (read_ptr),
        .wide        (cfg_wide),
        .ring_start  (ring_start),
        .ring_end    (ring_end),
        .host_wp     (host_wp),
        .rp_next     (rp_next),
        .next_hits_wp(next_hits_wp)
    );

    generate
        for (genvar k = 0; k < BEATS; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)                                     stage[k] <= '0;
                else if (beat_take && beat_idx == BEAT_IDX_W'(k)) stage[k] <= field;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            read_ptr  <= '0;
            entry_q   <= '0;
            exhausted <= 1'b0;
        end else begin
            exhausted <= commit && next_hits_wp;
            if (commit) begin
                read_ptr      <= rp_next;
                entry_q.base  <= {stage[1], stage[0]};
                entry_q.words <= {stage[3], stage[2]};
            end else if (rp_wr_en && !busy) begin
                read_ptr <= rp_wr_data;
            end
        end
    end

    assign mem_rd_addr = {ring_upper, read_ptr};
    assign buf_addr    = entry_q.base;
    assign buf_words   = entry_q.words;

    AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_ready |=> $stable(mem_rd_addr)); // R3
    AST_EXH_AT_WP: assert property (@(posedge clk) disable iff (rst)
        exhausted |-> read_ptr == $past(host_wp)); // R5
    AST_RP_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (rst)
        $past(commit) |-> (read_ptr == $past(read_ptr + entry_stride(cfg_wide))
                           || read_ptr == $past(ring_start))); // R4
    AST_EXH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> !exhausted); // R5
endmodule

// File: tb/rx_ring_fetch_tb.sv
module rx_ring_fetch_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b1, cfg_big_endian = 1'b0;
    logic [15:0] ring_upper = 16'h0012, ring_start = 16'h0100, ring_end = 16'h0140;
    logic [15:0] host_wp = 16'h0130;
    logic        rp_wr_en = 1'b0;
    logic [15:0] rp_wr_data = '0;
    logic        cmd_fetch = 1'b0, frame_end = 1'b0, frame_last = 1'b0;
    logic        mem_rd_req, mem_rd_ready, mem_rsp_valid;
    logic [31:0] mem_rd_addr, mem_rsp_data;
    logic [31:0] buf_addr, buf_words;
    logic [15:0] read_ptr;
    logic        cmd_pending, busy, exhausted, rx_blocked;

    int n_chk = 0, n_bad = 0;
    int req_count = 0, exh_count = 0, stall_left = 0;
    int mm_k = 0;
    logic [31:0] mm_base = '0, last_req_addr = '0;
    logic        mm_valid = 1'b0;
    logic [31:0] mm_data = '0;

    always #4 clk = ~clk;

    rx_ring_fetch u_dut (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_big_endian(cfg_big_endian),
        .ring_upper(ring_upper), .ring_start(ring_start), .ring_end(ring_end),
        .host_wp(host_wp), .rp_wr_en(rp_wr_en), .rp_wr_data(rp_wr_data),
        .cmd_fetch(cmd_fetch), .frame_end(frame_end), .frame_last(frame_last),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .buf_addr(buf_addr), .buf_words(buf_words), .read_ptr(read_ptr),
        .cmd_pending(cmd_pending), .busy(busy), .exhausted(exhausted),
        .rx_blocked(rx_blocked)
    );

    function automatic logic [31:0] slot_val(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3C3, a[15:0] ^ {a[23:16], 8'h11}};
    endfunction

    function automatic logic [15:0] exp_field(input logic [31:0] a, input logic w, input logic be);
        logic [31:0] s;
        s = slot_val(a);
        return (w && be) ? s[31:16] : s[15:0];
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] b, input int k, input logic w);
        return b + 32'(k * (w ? 4 : 2));
    endfunction

    assign mem_rd_ready  = (stall_left == 0);
    assign mem_rsp_valid = mm_valid;
    assign mem_rsp_data  = mm_data;

    always @(posedge clk) begin
        if (rst) begin
            mm_valid <= 1'b0;
        end else begin
            if (mem_rd_req && stall_left > 0) stall_left <= stall_left - 1;
            if (mem_rd_req && mem_rd_ready) begin
                mm_base       <= mem_rd_addr;
                last_req_addr <= mem_rd_addr;
                req_count     <= req_count + 1;
                mm_valid      <= 1'b1;
                mm_data       <= slot_val(slot_addr(mem_rd_addr, 0, cfg_wide));
                mm_k          <= 1;
            end else if (mm_valid) begin
                if (mm_k < 4) begin
                    mm_data <= slot_val(slot_addr(mm_base, mm_k, cfg_wide));
                    mm_k    <= mm_k + 1;
                end else begin
                    mm_valid <= 1'b0;
                end
            end
            if (exhausted) exh_count <= exh_count + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (3) @(negedge clk);
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic set_rp(input logic [15:0] v);
        @(negedge clk);
        rp_wr_en = 1'b1; rp_wr_data = v;
        @(negedge clk);
        rp_wr_en = 1'b0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk);
        cmd_fetch = 1'b1;
        @(negedge clk);
        cmd_fetch = 1'b0;
    endtask

    task automatic pulse_frame(input logic last);
        @(negedge clk);
        frame_end = 1'b1; frame_last = last;
        @(negedge clk);
        frame_end = 1'b0; frame_last = 1'b0;
    endtask

    task automatic check_entry(input string req, input logic [31:0] base);
        logic [31:0] ea, ew;
        ea = {exp_field(slot_addr(base, 1, cfg_wide), cfg_wide, cfg_big_endian),
              exp_field(slot_addr(base, 0, cfg_wide), cfg_wide, cfg_big_endian)};
        ew = {exp_field(slot_addr(base, 3, cfg_wide), cfg_wide, cfg_big_endian),
              exp_field(slot_addr(base, 2, cfg_wide), cfg_wide, cfg_big_endian)};
        check({req, " base"}, buf_addr, ea);
        check({req, " words"}, buf_words, ew);
    endtask

    task automatic t_reset();
        check("R11 read_ptr", 32'(read_ptr), 0);
        check("R11 buf_addr", buf_addr, 0);
        check("R11 buf_words", buf_words, 0);
        check("R11 flags", {27'd0, busy, cmd_pending, rx_blocked, exhausted, mem_rd_req}, 0);
    endtask

    task automatic t_wide_little();
        int e0 = exh_count;
        cfg_wide = 1'b1; cfg_big_endian = 1'b0;
        set_rp(16'h0100);
        pulse_cmd();
        check("R8 pending set", 32'(cmd_pending), 1);
        wait_idle();
        check("R3 request address", last_req_addr, 32'h0012_0100);
        check_entry("R1 R9 little", 32'h0012_0100);
        check("R2 wide stride", 32'(read_ptr), 32'h0110);
        check("R8 pending cleared", 32'(cmd_pending), 0);
        check("R5 no pulse", 32'(exh_count - e0), 0);
    endtask

    task automatic t_wide_big();
        cfg_big_endian = 1'b1;
        pulse_cmd();
        wait_idle();
        check_entry("R9 big", 32'h0012_0110);
        check("R4 advance", 32'(read_ptr), 32'h0120);
        cfg_big_endian = 1'b0;
    endtask

    task automatic t_exhaust();
        int e0 = exh_count;
        pulse_cmd();
        wait_idle();
        check("R4 advance to wp", 32'(read_ptr), 32'h0130);
        check("R5 one pulse", 32'(exh_count - e0), 1);
    endtask

    task automatic t_wrap();
        int e0 = exh_count;
        pulse_cmd();
        wait_idle();
        check_entry("R1 last entry", 32'h0012_0130);
        check("R4 wrap to start", 32'(read_ptr), 32'h0100);
        check("R5 no pulse on wrap", 32'(exh_count - e0), 0);
    endtask

    task automatic t_narrow();
        cfg_wide = 1'b0;
        set_rp(16'h0100);
        pulse_cmd();
        wait_idle();
        check_entry("R2 narrow", 32'h0012_0100);
        check("R2 narrow stride", 32'(read_ptr), 32'h0108);
    endtask

    task automatic t_frame_block();
        int r0 = req_count;
        host_wp = 16'h0108;
        pulse_frame(1'b1);
        wait_idle();
        check("R7 blocked at wp", 32'(rx_blocked), 1);
        check("R7 no request", 32'(req_count - r0), 0);
        check("R7 rp kept", 32'(read_ptr), 32'h0108);
    endtask

    task automatic t_frame_nolast();
        int r0 = req_count;
        host_wp = 16'h0130;
        pulse_frame(1'b0);
        wait_idle();
        check("R7 no-last no request", 32'(req_count - r0), 0);
        check("R7 no-last rp kept", 32'(read_ptr), 32'h0108);
        check("R7 no-last still blocked", 32'(rx_blocked), 1);
    endtask

    task automatic t_unblock();
        pulse_cmd();
        wait_idle();
        check("R6 cleared by fetch", 32'(rx_blocked), 0);
        check("R2 narrow second", 32'(read_ptr), 32'h0110);
    endtask

    task automatic t_frame_fetch();
        int r0 = req_count;
        pulse_frame(1'b1);
        wait_idle();
        check("R7 fetch on last", 32'(req_count - r0), 1);
        check_entry("R7 entry", 32'h0012_0110);
        check("R7 rp advanced", 32'(read_ptr), 32'h0118);
        check("R8 pending untouched", 32'(cmd_pending), 0);
    endtask

    task automatic t_held();
        int r0 = req_count;
        logic [31:0] a0;
        stall_left = 5;
        pulse_cmd();
        @(negedge clk);
        a0 = mem_rd_addr;
        check("R10 busy", 32'(busy), 1);
        pulse_frame(1'b1);
        check("R3 held address", mem_rd_addr, a0);
        wait_idle();
        wait_idle();
        check("R10 both served", 32'(req_count - r0), 2);
        check("R10 rp after two", 32'(read_ptr), 32'h0128);
        check_entry("R10 second entry", 32'h0012_0120);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_little();
        t_wide_big();
        t_exhaust();
        t_wrap();
        t_narrow();
        t_frame_block();
        t_frame_nolast();
        t_unblock();
        t_frame_fetch();
        t_held();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule